// File: doc/BRIEF.md
# PCI Bus Target Transaction Controller

This block is a simplified 32-bit PCI bus target. It watches the address phase, works out whether the access falls inside its memory window, its I/O window or its configuration space, and then runs the data phases against a small internal register file. It produces DEVSEL#, TRDY# and STOP#, plus drive enables for them, for the AD bus and for PERR#. A surrounding pad ring turns these enables into tri-state drivers. On writes, each byte lane of a word is updated only when its active-low byte enable is low.

Addresses arrive in one of two forms. A single-address cycle carries the 32-bit address and the command in one clock. A dual address cycle takes two clocks: the first carries the low address word with the dual-address command, and the second carries the high word with the real command. On reads the target leaves one turnaround cycle before it drives AD and asserts TRDY#. If the word index reaches past the implemented registers, the target signals STOP# without TRDY#, so that phase moves no data. After every claimed transaction it drives its control lines high for one clock before releasing them, and it accepts a new address phase in that same clock.

Top module: `pcit_target`

## Requirements
- R1: The command code is sampled on cbe_n during the final address phase. The codes are: 0010 I/O read, 0011 I/O write, 0110/1100/1110 memory read, 0111/1111 memory write, 1010 config read, 1011 config write, 1101 dual address. A memory or I/O command whose address lies in the matching window (upper address bits above AW equal to the base) is claimed, with devsel_n low in the first cycle after the final address phase. Any other address is never claimed.
- R2: On a write data phase that transfers, byte lane b (bits 8b+7..8b) of the addressed register takes ad_in only when cbe_n[b] is 0. Lanes whose enable is 1 keep their old value.
- R3: A word moves only on a clock edge where irdy_n and trdy_n are both low. Cycles with irdy_n high move nothing. Each transfer advances the register index by one.
- R4: On a write, trdy_n falls in the same cycle as devsel_n. On a read, trdy_n falls one cycle after devsel_n. ad_oe is high exactly in the read cycles where trdy_n is low.
- R5: A dual address cycle (1101 in the first address cycle, real command in the second) is decoded on the 64-bit address {second AD word, first AD word}. It is claimed one cycle after the second phase, only for memory commands whose 64-bit address hits the window whose upper word is MEM_HI. A single-address cycle implies an upper word of zero.
- R6: A configuration command is claimed only if idsel is 1 and ad_in[1:0] is 00 in its address phase. Register word (ad_in[AW-1:2]) is then accessed.
- R7: When the current word index is NREGS or above, the target holds stop_n low and trdy_n high, so no data moves. The transaction ends once frame_n is high and irdy_n is low.
- R8: After the final data phase (frame_n high, irdy_n low, completed by TRDY# or STOP#), the target spends one cycle with ctl_oe high and trdy_n, devsel_n and stop_n all high. ctl_oe then goes low.
- R9: An address phase that arrives in that drive-high cycle, with no idle cycle, is decoded and claimed with the same timing as one from idle.
- R10: perr_oe is high only in write data phases of a claimed transaction. perr_n stays high.
- R11: A special cycle (command 0001) is never claimed and writes nothing.
- R12: During reset, trdy_n, devsel_n, stop_n and perr_n are high, and ctl_oe, ad_oe and perr_oe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Transaction framing from the initiator |
| irdy_n | input | 1 | Initiator ready |
| idsel | input | 1 | Configuration select for this device |
| cbe_n | input | 4 | Command in address phases, byte enables in data phases |
| ad_in | input | 32 | Address/data bus as seen by the target |
| ad_out | output | 32 | Read data driven onto AD |
| ad_oe | output | 1 | Drive enable for ad_out |
| trdy_n | output | 1 | Target ready |
| devsel_n | output | 1 | Device select (claim) |
| stop_n | output | 1 | Stop / disconnect request |
| ctl_oe | output | 1 | Drive enable for trdy_n, devsel_n, stop_n |
| perr_n | output | 1 | Data parity error (held inactive) |
| perr_oe | output | 1 | Drive enable for perr_n |

## Verification
The bench builds the target with AW = 5 and NREGS = 6. This gives an eight-word window in which only six words have storage, so both a disconnect at the first data phase and a disconnect partway through a burst can be reached with short transfers. With the window this small, all sixteen byte-enable patterns can be swept on one register and each read back against an arithmetic lane mask. MEM_HI stays zero, so single-address and dual-address accesses reach the same window, and a dual cycle with a nonzero upper word shows the miss.

// File: rtl/pcit_pkg.sv
package pcit_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DAC2, ST_TURNAR, ST_DATA, ST_RELEASE, ST_BUSY
  } tgt_state_e;

  typedef enum logic [1:0] {SP_NONE, SP_IO, SP_MEM, SP_CFG} space_e;

  localparam logic [3:0] CMD_DUAL = 4'b1101;

  // Address space a bus command refers to.
  function automatic space_e cmd_space(input logic [3:0] c);
    case (c)
      4'b0010, 4'b0011:                            return SP_IO;
      4'b0110, 4'b0111, 4'b1100, 4'b1110, 4'b1111: return SP_MEM;
      4'b1010, 4'b1011:                            return SP_CFG;
      default:                                     return SP_NONE;
    endcase
  endfunction

  function automatic logic cmd_is_read(input logic [3:0] c);
    return (c == 4'b0010) || (c == 4'b0110) || (c == 4'b1010) ||
           (c == 4'b1100) || (c == 4'b1110);
  endfunction

  // Lane-wise merge: an active-low enable selects the new byte.
  function automatic logic [31:0] merge_lanes(input logic [31:0] old_w,
                                              input logic [31:0] new_w,
                                              input logic [3:0]  be_n);
    logic [31:0] r;
    for (int b = 0; b < 4; b++)
      r[8*b +: 8] = be_n[b] ? old_w[8*b +: 8] : new_w[8*b +: 8];
    return r;
  endfunction

  // Window compare: all bits above the window size must match.
  function automatic logic window_hit(input logic [63:0] a,
                                      input logic [63:0] base,
                                      input int unsigned aw);
    return (a >> aw) == (base >> aw);
  endfunction

endpackage

// File: rtl/pcit_decode.sv
module pcit_decode
  import pcit_pkg::*;
#(
  parameter int          AW       = 6,
  parameter logic [31:0] MEM_BASE = 32'h8000_0000,
  parameter logic [31:0] MEM_HI   = 32'h0000_0000,
  parameter logic [31:0] IO_BASE  = 32'h0000_1000,
  localparam int         IDXW     = AW - 2
) (
  input  logic [3:0]      cmd,
  input  logic [31:0]     lo,
  input  logic [31:0]     hi,
  input  logic            dual,
  input  logic            idsel,
  output logic            claim,
  output logic            rd,
  output logic [IDXW-1:0] start_idx
);
  space_e sp;
  logic   mem_hit, io_hit, cfg_hit;

  always_comb begin
    sp        = cmd_space(cmd);
    mem_hit   = window_hit({hi, lo}, {MEM_HI, MEM_BASE}, AW);
    io_hit    = !dual && window_hit({32'h0, lo}, {32'h0, IO_BASE}, AW);
    cfg_hit   = !dual && idsel && (lo[1:0] == 2'b00);
    case (sp)
      SP_MEM:  claim = mem_hit;
      SP_IO:   claim = io_hit;
      SP_CFG:  claim = cfg_hit;
      default: claim = 1'b0;
    endcase
    rd        = cmd_is_read(cmd);
    start_idx = lo[AW-1:2];
  end
endmodule

// File: rtl/pcit_regfile.sv
module pcit_regfile
  import pcit_pkg::*;
#(
  parameter int NREGS = 12,
  parameter int IDXW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IDXW-1:0] widx,
  input  logic [3:0]      be_n,
  input  logic [31:0]     wdata,
  input  logic [IDXW:0]   ridx,
  output logic [31:0]     rdata
);
  localparam logic [IDXW:0] LIMIT = (IDXW+1)'(NREGS);

  logic [31:0] regs [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (we && widx == IDXW'(g))
        regs[g] <= merge_lanes(regs[g], wdata, be_n);
    end
  end

  always_comb
    rdata = (ridx < LIMIT) ? regs[ridx[IDXW-1:0]] : '0;
endmodule

// File: rtl/pcit_fsm.sv
module pcit_fsm
  import pcit_pkg::*;
#(
  parameter int NREGS = 12,
  parameter int IDXW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_n,
  input  logic            irdy_n,
  input  logic [3:0]      cbe_n,
  input  logic [31:0]     ad_in,
  input  logic            dec_claim,
  input  logic            dec_rd,
  input  logic [IDXW-1:0] dec_idx,
  output tgt_state_e      st,
  output logic [31:0]     lat_lo,
  output logic            addr_phase,
  output logic            decode_now,
  output logic            is_rd,
  output logic [IDXW:0]   idx,
  output logic            xfer,
  output logic            disc
);
  localparam logic [IDXW:0] LIMIT = (IDXW+1)'(NREGS);

  always_comb begin
    addr_phase = ((st == ST_IDLE) || (st == ST_RELEASE)) && !frame_n;
    decode_now = (addr_phase && cbe_n != CMD_DUAL) || (st == ST_DAC2);
    disc       = (st == ST_DATA) && (idx >= LIMIT);
    xfer       = (st == ST_DATA) && !disc && !irdy_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      lat_lo <= '0;
      is_rd  <= 1'b0;
      idx    <= '0;
    end else begin
      if (addr_phase) lat_lo <= ad_in;
      if (decode_now) begin
        if (dec_claim) begin
          st    <= dec_rd ? ST_TURNAR : ST_DATA;
          is_rd <= dec_rd;
          idx   <= {1'b0, dec_idx};
        end else begin
          st <= ST_BUSY;
        end
      end else if (addr_phase) begin
        st <= ST_DAC2;
      end else begin
        case (st)
          ST_TURNAR: st <= ST_DATA;
          ST_DATA: begin
            if (xfer) begin
              idx <= idx + 1'b1;
              if (frame_n) st <= ST_RELEASE;
            end else if (disc && frame_n && !irdy_n) begin
              st <= ST_RELEASE;
            end
          end
          ST_RELEASE: st <= ST_IDLE;
          ST_BUSY:    if (frame_n && irdy_n) st <= ST_IDLE;
          default:    ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pcit_target.sv
module pcit_target
  import pcit_pkg::*;
#(
  parameter int          AW       = 6,
  parameter int          NREGS    = 12,
  parameter logic [31:0] MEM_BASE = 32'h8000_0000,
  parameter logic [31:0] MEM_HI   = 32'h0000_0000,
  parameter logic [31:0] IO_BASE  = 32'h0000_1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_n,
  input  logic        irdy_n,
  input  logic        idsel,
  input  logic [3:0]  cbe_n,
  input  logic [31:0] ad_in,
  output logic [31:0] ad_out,
  output logic        ad_oe,
  output logic        trdy_n,
  output logic        devsel_n,
  output logic        stop_n,
  output logic        ctl_oe,
  output logic        perr_n,
  output logic        perr_oe
);
  localparam int IDXW = AW - 2;

  tgt_state_e      st;
  logic [31:0]     lat_lo, dec_lo, dec_hi, rdata;
  logic            in_dac2, dec_claim, dec_rd;
  logic [IDXW-1:0] dec_idx;
  logic            addr_phase, decode_now, is_rd, xfer, disc;
  logic [IDXW:0]   idx;

  always_comb begin
    in_dac2 = (st == ST_DAC2);
    dec_lo  = in_dac2 ? lat_lo : ad_in;
    dec_hi  = in_dac2 ? ad_in  : 32'h0;
  end

  pcit_decode #(
    .AW(AW), .MEM_BASE(MEM_BASE), .MEM_HI(MEM_HI), .IO_BASE(IO_BASE)
  ) u_decode (
    .cmd(cbe_n), .lo(dec_lo), .hi(dec_hi), .dual(in_dac2), .idsel(idsel),
    .claim(dec_claim), .rd(dec_rd), .start_idx(dec_idx)
  );

  pcit_fsm #(.NREGS(NREGS), .IDXW(IDXW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .cbe_n(cbe_n), .ad_in(ad_in), .dec_claim(dec_claim), .dec_rd(dec_rd),
    .dec_idx(dec_idx), .st(st), .lat_lo(lat_lo), .addr_phase(addr_phase),
    .decode_now(decode_now), .is_rd(is_rd), .idx(idx), .xfer(xfer),
    .disc(disc)
  );

  pcit_regfile #(.NREGS(NREGS), .IDXW(IDXW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(xfer && !is_rd), .widx(idx[IDXW-1:0]),
    .be_n(cbe_n), .wdata(ad_in), .ridx(idx), .rdata(rdata)
  );

  always_comb begin
    ctl_oe   = (st == ST_TURNAR) || (st == ST_DATA) || (st == ST_RELEASE);
    devsel_n = !((st == ST_TURNAR) || (st == ST_DATA));
    trdy_n   = !((st == ST_DATA) && !disc);
    stop_n   = !disc;
    ad_oe    = (st == ST_DATA) && is_rd && !disc;
    ad_out   = ad_oe ? rdata : 32'h0;
    perr_oe  = (st == ST_DATA) && !is_rd;
    perr_n   = 1'b1;
  end
endmodule

// File: rtl/pcit_checker.sv
module pcit_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       irdy_n,
  input logic       idsel,
  input logic [3:0] cbe_n,
  input logic       trdy_n,
  input logic       devsel_n,
  input logic       stop_n,
  input logic       ctl_oe,
  input logic       ad_oe,
  input logic       perr_oe,
  input logic       addr_phase,
  input logic       xfer
);
  assert_xfer_handshake_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |-> (!irdy_n && !trdy_n));

  assert_trdy_needs_devsel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n |-> !devsel_n);

  assert_read_turnaround_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ad_oe) |-> ($past(!devsel_n) && $past(trdy_n) && !ctl_oe == 1'b0));

  assert_dual_delays_claim_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_phase && cbe_n == 4'b1101) |=> devsel_n);

  assert_cfg_needs_idsel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_phase && cbe_n[3:1] == 3'b101 && !idsel) |=> devsel_n);

  assert_stop_without_trdy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_n |-> (trdy_n && !devsel_n));

  assert_release_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_oe) |-> ($past(trdy_n) && $past(devsel_n) && $past(stop_n)));

  assert_perr_in_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    perr_oe |-> (!devsel_n && ctl_oe && !ad_oe));

  assert_special_unclaimed_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_phase && cbe_n == 4'b0001) |=> devsel_n);
endmodule

bind pcit_target pcit_checker u_chk (
  .clk(clk), .rst_n(rst_n), .irdy_n(irdy_n), .idsel(idsel), .cbe_n(cbe_n),
  .trdy_n(trdy_n), .devsel_n(devsel_n), .stop_n(stop_n), .ctl_oe(ctl_oe),
  .ad_oe(ad_oe), .perr_oe(perr_oe), .addr_phase(addr_phase), .xfer(xfer)
);

// File: tb/pcit_target_bench.sv
`timescale 1ns/1ps
module pcit_target_bench;
  localparam int          AW    = 5;
  localparam int          NREGS = 6;
  localparam logic [31:0] MB    = 32'hA000_0000;
  localparam logic [31:0] IOB   = 32'h0000_2000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        frame_n, irdy_n, idsel;
  logic [3:0]  cbe_n;
  logic [31:0] ad_in, ad_out;
  logic        ad_oe, trdy_n, devsel_n, stop_n, ctl_oe, perr_n, perr_oe;

  always #2.5 clk = ~clk;

  pcit_target #(.AW(AW), .NREGS(NREGS), .MEM_BASE(MB), .MEM_HI(32'h0),
                .IO_BASE(IOB)) u_pcit_target (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .idsel(idsel), .cbe_n(cbe_n), .ad_in(ad_in), .ad_out(ad_out),
    .ad_oe(ad_oe), .trdy_n(trdy_n), .devsel_n(devsel_n), .stop_n(stop_n),
    .ctl_oe(ctl_oe), .perr_n(perr_n), .perr_oe(perr_oe)
  );

  int checks = 0, errors = 0;
  logic [31:0] model [8];
  logic [31:0] wdat [8];
  logic [3:0]  wbe [8];
  logic [31:0] rdat [8];
  int got, t_dev, t_trdy, t_stop, perr_bad, oe_bad;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    logic [31:0] m = 32'h0;
    for (int b = 0; b < 4; b++) if (!be[b]) m = m + (32'hFF << (8 * b));
    return m;
  endfunction

  task automatic apply(input int idx, input int n);
    for (int i = 0; i < n; i++)
      if (idx + i < NREGS)
        model[idx+i] = (model[idx+i] & ~lane_mask(wbe[i])) | (wdat[i] & lane_mask(wbe[i]));
  endtask

  // Caller is at a negedge; returns at the negedge after the last bus cycle.
  task automatic txn(input logic [3:0] cmd, input logic [31:0] lo, input bit dual,
                     input logic [31:0] hi, input bit sel, input int n, input bit stall);
    bit wr = cmd[0];
    int c = 0, k = 0;
    bit fin = 0, ending = 0;
    got = 0; t_dev = -1; t_trdy = -1; t_stop = -1; perr_bad = 0; oe_bad = 0;
    frame_n = 0; irdy_n = 1; idsel = sel; ad_in = lo;
    cbe_n = dual ? 4'b1101 : cmd;
    if (dual) begin
      @(negedge clk);
      idsel = 0; ad_in = hi; cbe_n = cmd;
    end
    @(negedge clk);
    idsel = 0;
    while (!fin && c < 16) begin
      irdy_n  = (stall && (c % 2 == 1) && k < n - 1 && !ending);
      frame_n = ending || (k == n - 1);
      cbe_n   = wr ? wbe[k] : 4'b0000;
      ad_in   = wr ? wdat[k] : 32'h0;
      #0;
      if (!devsel_n && t_dev < 0) t_dev = c;
      if (!trdy_n && t_trdy < 0) t_trdy = c;
      if (!stop_n && t_stop < 0) t_stop = c;
      if (perr_oe != (wr && !devsel_n)) perr_bad++;
      if (ad_oe != (!wr && !trdy_n)) oe_bad++;
      if (!trdy_n && !irdy_n) begin
        if (!wr) rdat[k] = ad_out;
        k++; got++;
        if (frame_n) fin = 1;
      end else if (!stop_n) begin
        if (frame_n) fin = 1; else ending = 1;
      end else if (devsel_n && c >= 4) begin
        fin = 1;
      end
      c++;
      @(negedge clk);
    end
    frame_n = 1; irdy_n = 1; cbe_n = 4'hF; ad_in = 32'h0;
  endtask

  task automatic release_check(input string tag);
    chk(ctl_oe && trdy_n && devsel_n && stop_n, "R8", {tag, " drive-high cycle"},
        {28'h0, ctl_oe, trdy_n, devsel_n, stop_n}, 32'hF);
    @(negedge clk);
    chk(!ctl_oe, "R8", {tag, " release"}, {31'h0, ctl_oe}, 32'h0);
  endtask

  task automatic read_word(input logic [3:0] cmd, input logic [31:0] addr,
                           input bit sel, input int idx, input string req);
    txn(cmd, addr, 0, 0, sel, 1, 0);
    chk(got == 1 && rdat[0] == model[idx], req, "read back", rdat[0], model[idx]);
    @(negedge clk);
  endtask

  initial begin
    frame_n = 1; irdy_n = 1; idsel = 0; cbe_n = 4'hF; ad_in = 32'h0;
    for (int i = 0; i < 8; i++) model[i] = 32'h0;
    repeat (3) @(negedge clk);
    chk(trdy_n && devsel_n && stop_n && perr_n && !ctl_oe && !ad_oe && !perr_oe,
        "R12", "reset outputs",
        {25'h0, trdy_n, devsel_n, stop_n, perr_n, ctl_oe, ad_oe, perr_oe}, 32'h78);
    rst_n = 1;
    @(negedge clk);

    // Config write burst, idsel high (R6, R4, R3, R10)
    for (int i = 0; i < 4; i++) begin wdat[i] = 32'hC0DE_0000 + i * 32'h0101; wbe[i] = 4'h0; end
    txn(4'b1011, 32'h0, 0, 0, 1, 4, 0);
    apply(0, 4);
    chk(got == 4, "R3", "cfg write count", got, 4);
    chk(t_dev == 0 && t_trdy == 0, "R4", "write trdy with devsel", t_trdy, 0);
    chk(perr_bad == 0, "R10", "perr enable in write data", perr_bad, 0);
    release_check("cfg write");

    // Config read burst with initiator wait states (R3, R4, R6)
    txn(4'b1010, 32'h0, 0, 0, 1, 4, 1);
    chk(got == 4, "R3", "cfg read count", got, 4);
    chk(t_dev == 0 && t_trdy == 1, "R4", "read turnaround", t_trdy, 1);
    chk(oe_bad == 0 && perr_bad == 0, "R4", "ad_oe only with read trdy", oe_bad, 0);
    for (int i = 0; i < 4; i++)
      chk(rdat[i] == model[i], "R3", "cfg burst read data", rdat[i], model[i]);
    release_check("cfg read");

    // Config write without idsel is ignored (R6)
    wdat[0] = 32'hFFFF_FFFF; wbe[0] = 4'h0;
    txn(4'b1011, 32'h4, 0, 0, 0, 1, 0);
    chk(t_dev < 0, "R6", "no claim without idsel", t_dev, 32'hFFFF_FFFF);
    @(negedge clk);
    read_word(4'b1010, 32'h4, 1, 1, "R6");

    // Byte-enable sweep on I/O word 2 (R2, R1)
    for (int be = 0; be < 16; be++) begin
      wdat[0] = {4{4'(be), 4'(~be)}} ^ (32'h1357_9BDF * be);
      wbe[0]  = 4'(be);
      txn(4'b0011, IOB + 32'h8, 0, 0, 0, 1, 0);
      apply(2, 1);
      @(negedge clk);
      read_word(4'b0010, IOB + 32'h8, 0, 2, "R2");
    end

    // Memory single-address burst write with waits, then read multiple (R1, R3)
    for (int i = 0; i < 3; i++) begin wdat[i] = 32'h5A00_0000 | (i << 8) | i; wbe[i] = 4'h0; end
    txn(4'b0111, MB + 32'hC, 0, 0, 0, 3, 1);
    apply(3, 3);
    chk(got == 3 && t_dev == 0, "R1", "memory claim and count", got, 3);
    @(negedge clk);
    txn(4'b1100, MB + 32'hC, 0, 0, 0, 3, 0);
    for (int i = 0; i < 3; i++)
      chk(rdat[i] == model[3+i], "R3", "memory burst read", rdat[i], model[3+i]);
    @(negedge clk);
    read_word(4'b1110, MB + 32'h14, 0, 5, "R1");

    // Dual address cycle hit and miss (R5)
    wdat[0] = 32'hDAC0_0001; wbe[0] = 4'h0;
    txn(4'b0111, MB, 1, 32'h0, 0, 1, 0);
    apply(0, 1);
    chk(t_dev == 0 && got == 1, "R5", "dual write claim timing", t_dev, 0);
    @(negedge clk);
    txn(4'b0110, MB, 1, 32'h0, 0, 1, 0);
    chk(t_trdy == 1 && rdat[0] == model[0], "R5", "dual read data", rdat[0], model[0]);
    @(negedge clk);
    wdat[0] = 32'hBAD0_BAD0;
    txn(4'b0111, MB, 1, 32'h1, 0, 1, 0);
    chk(t_dev < 0, "R5", "dual upper word miss", t_dev, 32'hFFFF_FFFF);
    @(negedge clk);
    read_word(4'b0110, MB, 0, 0, "R5");

    // Special cycle and window miss (R11, R1)
    wdat[0] = 32'h0BAD_CAFE;
    txn(4'b0001, MB, 0, 0, 0, 1, 0);
    chk(t_dev < 0, "R11", "special cycle not claimed", t_dev, 32'hFFFF_FFFF);
    @(negedge clk);
    read_word(4'b0110, MB, 0, 0, "R11");
    txn(4'b0011, IOB + 32'h100, 0, 0, 0, 1, 0);
    chk(t_dev < 0, "R1", "I/O address miss", t_dev, 32'hFFFF_FFFF);
    @(negedge clk);

    // Disconnect without data (R7)
    txn(4'b0110, MB + 32'h18, 0, 0, 0, 2, 0);
    chk(got == 0 && t_stop == 1 && t_trdy < 0, "R7", "read disconnect", t_stop, 1);
    release_check("read disconnect");
    wdat[0] = 32'h7777_7777; wbe[0] = 4'h0;
    txn(4'b0111, MB + 32'h1C, 0, 0, 0, 1, 0);
    chk(got == 0 && t_stop == 0, "R7", "write disconnect", t_stop, 0);
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin wdat[i] = 32'hE000_0000 + i; wbe[i] = 4'h0; end
    txn(4'b0111, MB + 32'h10, 0, 0, 0, 4, 0);
    apply(4, 4);
    chk(got == 2 && t_stop == 2, "R7", "burst stops at end", got, 2);
    @(negedge clk);
    read_word(4'b0110, MB + 32'h14, 0, 5, "R7");

    // Back-to-back: new address in the drive-high cycle (R9)
    wdat[0] = 32'h0B2B_0B2B; wbe[0] = 4'h0;
    txn(4'b0011, IOB + 32'h4, 0, 0, 0, 1, 0);
    apply(1, 1);
    chk(ctl_oe && devsel_n && trdy_n, "R9", "in drive-high cycle", {31'h0, ctl_oe}, 1);
    txn(4'b0010, IOB + 32'h4, 0, 0, 0, 1, 0);
    chk(t_dev == 0 && t_trdy == 1 && rdat[0] == model[1], "R9", "back-to-back read",
        rdat[0], model[1]);
    release_check("back-to-back");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule